// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is a single channel of a 16-bit timer. It watches a free-running count supplied from outside and, depending on its configuration, either records the count when an edge arrives on its pin or drives its pin from comparisons between the count and a stored value. It covers four functions: input capture, output compare, edge-aligned PWM and center-aligned PWM. The counter, its prescaler, its modulo limit and any interrupt logic live outside. The channel receives the count, a direction flag, a period-start pulse and a timer-wide center-aligned select.

A 2-bit function field and a 2-bit edge/action field choose the behaviour. Software reaches the 16-bit channel value over an 8-bit bus as a high byte and a low byte. In capture mode the first byte read freezes a snapshot so that the two halves always belong to one capture. Writes are staged: the high byte waits in a holding register until the low byte arrives, and then both bytes load together. Every capture or compare match raises a sticky event flag, which a write-one-to-clear strobe removes.

Top module: `tmr_chan`

## Requirements
- R1: After reset the channel value is 0x0000, `pin_out` is 0, `pin_oe` is 0 and `flag_out` is 0.
- R2: When `ch_edge` is 00, in every function and with either `ctr_mode` value, the channel is idle. `pin_oe` is 0, `pin_out` is 0, no capture happens and `flag_out` is never set.
- R3: With `ctr_mode`=0 and `ch_mode`=00, the channel captures. It uses rising pin edges for `ch_edge`=01, falling edges for 10, and both for 11. `pin_in` passes through two synchronizer flops. The stored value is the `cnt_val` present at the third rising clock edge at which the new pin level is applied. In this mode `pin_oe` and `pin_out` stay 0.
- R4: In capture mode, reading either byte (`rd_hi` or `rd_lo` high for one cycle) freezes a 16-bit snapshot. Until the other byte has been read, reads return the snapshot even if new captures occur. A read of the high byte returns bits 15:8 and a read of the low byte returns bits 7:0.
- R5: A write to the high byte is held back. The channel value changes only when the low byte is written, and it then becomes {held high byte, written low byte}. Apart from that, only a capture changes it.
- R6: With `ctr_mode`=0 and `ch_mode`=01, the channel does output compare and `pin_oe` is 1. A match occurs in the cycle where `cnt_val` first equals the value. On the following edge, `pin_out` toggles for `ch_edge`=01, goes to 0 for 10, and goes to 1 for 11.
- R7: With `ctr_mode`=0 and `ch_mode`=1x, the channel does edge-aligned PWM. For `ch_edge`=10, a match drives `pin_out` to 0 and `cnt_wrap` drives it to 1. For `ch_edge`=x1 the levels are swapped. A match in the same cycle as `cnt_wrap` wins. In steady state, with a count of c and a value v, the high-true output is (c < v).
- R8: With `ctr_mode`=1 and `ch_edge` not 00, the channel does center-aligned PWM. For `ch_edge`=10, a match while counting up (`cnt_down`=0) drives `pin_out` to 0, and a match while counting down drives it to 1. For x1 the levels are swapped.
- R9: A capture or compare match sets `flag_out` on the next edge. The flag stays set until `flag_clr` is high at an edge with no new event, and a new event in the same cycle as `flag_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | 16 | Current timer count |
| cnt_down | input | 1 | Count direction, 1 while counting down |
| cnt_wrap | input | 1 | One-cycle pulse in the first cycle of a new period |
| ctr_mode | input | 1 | Timer-wide center-aligned select |
| ch_mode | input | 2 | Channel function select |
| ch_edge | input | 2 | Capture edge, compare action or PWM polarity |
| pin_in | input | 1 | Asynchronous pin level for capture |
| pin_out | output | 1 | Driven pin level |
| pin_oe | output | 1 | Pin drive enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the event flag |
| flag_out | output | 1 | Sticky event flag |
| rd_hi | input | 1 | Read strobe, high byte |
| rd_lo | input | 1 | Read strobe, low byte |
| wr_hi | input | 1 | Write strobe, high byte |
| wr_lo | input | 1 | Write strobe, low byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the strobed byte |

## Verification
The bench builds the channel with its defaults: an 8-bit bus, a 16-bit value and two synchronizer stages. It drives the count itself over short ranges, a period of eight for edge-aligned PWM and a triangle peaking at six for center-aligned PWM. With these ranges every duty value of a period, including zero and values past the top, can be swept in full, and each output is predicted by a closed formula. Capture is swept over all four edge selects and both pin directions. The count changes every cycle during these sweeps, so one sweep checks both the edge choice and the exact capture cycle.

// File: rtl/tmr_chan_pkg.sv
`timescale 1ns/1ps
// Shared types for the timer channel: the decoded channel function and
// the decode from the raw select fields.
package tmr_chan_pkg;

    typedef enum logic [2:0] {
        FN_IDLE,
        FN_CAPT,
        FN_OCMP,
        FN_EPWM,
        FN_CPWM
    } chan_fn_e;

    // Map timer-wide center select and channel fields to one function.
    function automatic chan_fn_e decode_fn(input logic center,
                                           input logic [1:0] md,
                                           input logic [1:0] el);
        if (el == 2'b00) return FN_IDLE;
        if (center)      return FN_CPWM;
        if (md[1])       return FN_EPWM;
        if (md[0])       return FN_OCMP;
        return FN_CAPT;
    endfunction

endpackage

// File: rtl/tmr_chan_insync.sv
`timescale 1ns/1ps
// Pin synchronizer and edge detector.
// Assumes din is asynchronous; SYNC_STAGES must be at least 2.
// rise/fall are one-cycle pulses taken after the last sync stage.
module tmr_chan_insync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] chain_q;
    logic         last_q;

    // Shift the pin level through the synchronizer and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[TOP-1:0], din};
            last_q  <= chain_q[TOP];
        end
    end

    // Compare synchronized level against its previous value.
    always_comb begin
        rise = chain_q[TOP] & ~last_q;
        fall = ~chain_q[TOP] & last_q;
    end

endmodule

// File: rtl/tmr_chan_cmp.sv
`timescale 1ns/1ps
// Count comparator. Raises hit only in the first cycle where the count
// equals the reference, so a count held still yields one event.
module tmr_chan_cmp #(
    parameter int VAL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] cnt,
    input  logic [VAL_W-1:0] ref_val,
    output logic             hit
);
    logic eq;
    logic eq_q;

    // Equality of count and reference this cycle.
    always_comb eq = (cnt == ref_val);

    // Remember last cycle's equality for entry detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= 1'b0;
        else        eq_q <= eq;
    end

    // Event on entry into equality.
    always_comb hit = eq & ~eq_q;

endmodule

// File: rtl/tmr_chan_valreg.sv
`timescale 1ns/1ps
// Channel value register with byte access.
// Writes: high byte staged, full value loaded on low-byte write.
// Reads in capture mode: first byte read freezes a snapshot until the
// other byte is read. A capture takes priority over a low-byte write.
module tmr_chan_valreg #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capt_mode,
    input  logic                  cap_hit,
    input  logic [2*BYTE_W-1:0]   cap_data,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  rd_hi,
    input  logic                  rd_lo,
    output logic [2*BYTE_W-1:0]   val_q,
    output logic [BYTE_W-1:0]     rd_data
);
    localparam int VAL_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] hi_stage_q;
    logic [VAL_W-1:0]  snap_q;
    logic              lock_q;
    logic              want_lo_q;
    logic [VAL_W-1:0]  rd_src;
    logic              rd_any;
    logic              rd_other;

    // Stage high byte on its write.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_stage_q <= '0;
        else if (wr_hi) hi_stage_q <= wr_data;
    end

    // Load the value from a capture or a completed byte pair.
    always_ff @(posedge clk) begin
        if (!rst_n)       val_q <= '0;
        else if (cap_hit) val_q <= cap_data;
        else if (wr_lo)   val_q <= {hi_stage_q, wr_data};
    end

    // Decode read strobes against the pending half.
    always_comb begin
        rd_any   = rd_hi | rd_lo;
        rd_other = want_lo_q ? rd_lo : rd_hi;
    end

    // Snapshot lock for coherent reads in capture mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !capt_mode) begin
            lock_q    <= 1'b0;
            want_lo_q <= 1'b0;
            snap_q    <= '0;
        end else if (rd_any) begin
            if (!lock_q) begin
                lock_q    <= 1'b1;
                want_lo_q <= rd_hi;
                snap_q    <= val_q;
            end else if (rd_other) begin
                lock_q <= 1'b0;
            end
        end
    end

    // Select the byte that is returned.
    always_comb begin
        rd_src  = (capt_mode && lock_q) ? snap_q : val_q;
        rd_data = rd_hi ? rd_src[VAL_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
    end

endmodule

// File: rtl/tmr_chan_pinctl.sv
`timescale 1ns/1ps
// Pin action unit. Applies compare actions and PWM set/clear rules to a
// registered pin level. Idle and capture functions park the pin at 0.
// hit must already be qualified to compare-type functions.
module tmr_chan_pinctl
    import tmr_chan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  chan_fn_e fn,
    input  logic [1:0] el,
    input  logic     hit,
    input  logic     cnt_down,
    input  logic     cnt_wrap,
    output logic     pin_q
);
    logic low_true;

    // PWM polarity from the low edge/level bit.
    always_comb low_true = el[0];

    // Update the pin level per function.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            unique case (fn)
                FN_OCMP: begin
                    if (hit) begin
                        case (el)
                            2'b01:   pin_q <= ~pin_q;
                            2'b10:   pin_q <= 1'b0;
                            2'b11:   pin_q <= 1'b1;
                            default: pin_q <= pin_q;
                        endcase
                    end
                end
                FN_EPWM: begin
                    if (hit)           pin_q <= low_true;
                    else if (cnt_wrap) pin_q <= ~low_true;
                end
                FN_CPWM: begin
                    if (hit) pin_q <= cnt_down ? ~low_true : low_true;
                end
                default: pin_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
// Timer capture/compare/PWM channel, top level.
// Assumes cnt_val, cnt_down and cnt_wrap come from a counter in this
// clock domain; pin_in may be asynchronous.
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BYTE_W-1:0] cnt_val,
    input  logic                cnt_down,
    input  logic                cnt_wrap,
    input  logic                ctr_mode,
    input  logic [1:0]          ch_mode,
    input  logic [1:0]          ch_edge,
    input  logic                pin_in,
    output logic                pin_out,
    output logic                pin_oe,
    input  logic                flag_clr,
    output logic                flag_out,
    input  logic                rd_hi,
    input  logic                rd_lo,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [BYTE_W-1:0]   rd_data
);
    localparam int VAL_W = 2 * BYTE_W;

    chan_fn_e         fn;
    logic             capt_mode;
    logic             cmp_mode;
    logic             pin_rise;
    logic             pin_fall;
    logic             cap_hit;
    logic             raw_hit;
    logic             cmp_hit;
    logic [VAL_W-1:0] val_cur;
    logic             flag_q;

    // Decode function and qualify events.
    always_comb begin
        fn        = decode_fn(ctr_mode, ch_mode, ch_edge);
        capt_mode = (fn == FN_CAPT);
        cmp_mode  = (fn == FN_OCMP) || (fn == FN_EPWM) || (fn == FN_CPWM);
        cap_hit   = capt_mode & ((ch_edge[0] & pin_rise) | (ch_edge[1] & pin_fall));
        cmp_hit   = cmp_mode & raw_hit;
        pin_oe    = cmp_mode;
    end

    tmr_chan_insync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    tmr_chan_cmp #(.VAL_W(VAL_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt_val),
        .ref_val (val_cur),
        .hit     (raw_hit)
    );

    tmr_chan_valreg #(.BYTE_W(BYTE_W)) u_val (
        .clk       (clk),
        .rst_n     (rst_n),
        .capt_mode (capt_mode),
        .cap_hit   (cap_hit),
        .cap_data  (cnt_val),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_data   (wr_data),
        .rd_hi     (rd_hi),
        .rd_lo     (rd_lo),
        .val_q     (val_cur),
        .rd_data   (rd_data)
    );

    tmr_chan_pinctl u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .fn       (fn),
        .el       (ch_edge),
        .hit      (cmp_hit),
        .cnt_down (cnt_down),
        .cnt_wrap (cnt_wrap),
        .pin_q    (pin_out)
    );

    // Sticky event flag; a new event beats the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (cap_hit | cmp_hit) flag_q <= 1'b1;
        else if (flag_clr)         flag_q <= 1'b0;
    end

    always_comb flag_out = flag_q;

endmodule

// File: rtl/tmr_chan_chk.sv
`timescale 1ns/1ps
// Property checker for tmr_chan, attached by bind below.
module tmr_chan_chk
    import tmr_chan_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       ch_edge,
    input chan_fn_e         fn,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             flag_out,
    input logic             flag_clr,
    input logic             wr_lo,
    input logic             cap_hit,
    input logic             cmp_hit,
    input logic [VAL_W-1:0] val_cur
);

    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_edge == 2'b00) |-> !pin_oe);

    assert_flag_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_out) |-> ($past(ch_edge) != 2'b00));

    assert_cap_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_CAPT) |=> !pin_out);

    assert_val_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !cap_hit) |=> $stable(val_cur));

    assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fn == FN_OCMP && ch_edge == 2'b01 && cmp_hit) |=> (pin_out != $past(pin_out)));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_out && !flag_clr) |=> flag_out);

    assert_flag_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cap_hit && !cmp_hit) |=> !flag_out);

endmodule

bind tmr_chan tmr_chan_chk #(.VAL_W(2 * BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_edge  (ch_edge),
    .fn       (fn),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .flag_out (flag_out),
    .flag_clr (flag_clr),
    .wr_lo    (wr_lo),
    .cap_hit  (cap_hit),
    .cmp_hit  (cmp_hit),
    .val_cur  (val_cur)
);

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
// Sweep bench for tmr_chan with default parameters.
module sim_tmr_chan;
    localparam int BW = 8;
    localparam int VW = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [VW-1:0] cnt_val;
    logic          cnt_down, cnt_wrap, ctr_mode;
    logic [1:0]    ch_mode, ch_edge;
    logic          pin_in, flag_clr, rd_hi, rd_lo, wr_hi, wr_lo;
    logic [BW-1:0] wr_data;
    wire           pin_out, pin_oe, flag_out;
    wire  [BW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    tmr_chan u0 (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .cnt_wrap(cnt_wrap), .ctr_mode(ctr_mode), .ch_mode(ch_mode),
        .ch_edge(ch_edge), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .flag_clr(flag_clr), .flag_out(flag_out), .rd_hi(rd_hi), .rd_lo(rd_lo),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_byte(input bit hi, output logic [BW-1:0] d);
        rd_hi = hi;
        rd_lo = !hi;
        #1;
        d = rd_data;
        @(negedge clk);
        rd_hi = 1'b0;
        rd_lo = 1'b0;
    endtask

    task automatic rd16(output logic [VW-1:0] v);
        logic [BW-1:0] h, l;
        rd_byte(1'b1, h);
        rd_byte(1'b0, l);
        v = {h, l};
    endtask

    task automatic wr_byte(input bit hi, input logic [BW-1:0] d);
        wr_hi = hi;
        wr_lo = !hi;
        wr_data = d;
        @(negedge clk);
        wr_hi = 1'b0;
        wr_lo = 1'b0;
    endtask

    task automatic wr16(input logic [VW-1:0] v);
        wr_byte(1'b1, v[VW-1:BW]);
        wr_byte(1'b0, v[BW-1:0]);
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [VW-1:0] v;
        logic [BW-1:0] b;
        logic          exp;
        int            oc_el[3];
        int            pw_el[3];
        oc_el = '{1, 3, 2};
        pw_el = '{2, 1, 3};

        rst_n = 1'b0; cnt_val = '0; cnt_down = 0; cnt_wrap = 0; ctr_mode = 0;
        ch_mode = 2'b00; ch_edge = 2'b00; pin_in = 0; flag_clr = 0;
        rd_hi = 0; rd_lo = 0; wr_hi = 0; wr_lo = 0; wr_data = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 pin_out", 32'(pin_out), 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 flag", 32'(flag_out), 0);
        rd16(v);
        chk("R1 value", 32'(v), 0);

        // R3 capture sweep over edge selects and pin direction (R2 for select 00)
        for (int el = 0; el < 4; el++) begin
            for (int dir = 0; dir < 2; dir++) begin
                logic [VW-1:0] base;
                logic          trig;
                base = 16'h4000 + 16'(el * 16) + 16'(dir * 256);
                trig = (dir == 0) ? el[0] : el[1];
                ctr_mode = 0; ch_mode = 2'b00; ch_edge = 2'b00;
                pin_in = (dir == 1);
                cyc(4);
                wr16(16'h5A5A);
                clr_flag();
                ch_edge = 2'(el);
                cyc(1);
                pin_in = (dir == 0);
                cnt_val = base;
                for (int i = 1; i < 4; i++) begin
                    cyc(1);
                    cnt_val = base + 16'(i);
                end
                cyc(3);
                rd16(v);
                chk(el == 0 ? "R2 no capture when idle" : "R3 captured value", 32'(v),
                    32'(trig ? base + 16'd2 : 16'h5A5A));
                chk(el == 0 ? "R2 no flag when idle" : "R9 capture flag", 32'(flag_out), 32'(trig));
                chk("R3 pin_oe in capture", 32'(pin_oe), 0);
                chk("R3 pin_out in capture", 32'(pin_out), 0);
            end
        end

        // R4 coherent read across a later capture
        ch_edge = 2'b00; pin_in = 0; cyc(4);
        ch_edge = 2'b11; cnt_val = 16'hA1B2; cyc(1);
        pin_in = 1; cyc(5);
        rd_byte(1'b1, b);
        chk("R4 first high byte", 32'(b), 32'h A1);
        cnt_val = 16'hC3D4;
        pin_in = 0; cyc(5);
        rd_byte(1'b0, b);
        chk("R4 low byte from snapshot", 32'(b), 32'h B2);
        rd_byte(1'b1, b);
        chk("R4 fresh high byte", 32'(b), 32'h C3);
        rd_byte(1'b0, b);
        chk("R4 fresh low byte", 32'(b), 32'h D4);

        // R5 staged writes
        ch_mode = 2'b01; ch_edge = 2'b00; cyc(1);
        wr_byte(1'b1, 8'hAB);
        rd16(v);
        chk("R5 high write held", 32'(v), 32'h C3D4);
        wr_byte(1'b0, 8'hCD);
        rd16(v);
        chk("R5 pair loaded", 32'(v), 32'h ABCD);

        // R2 idle compare: no drive, no flag
        wr16(16'd5);
        clr_flag();
        for (int c = 0; c < 8; c++) begin
            cnt_val = 16'(c);
            cyc(1);
            chk("R2 idle pin_oe", 32'(pin_oe), 0);
            chk("R2 idle pin_out", 32'(pin_out), 0);
        end
        chk("R2 idle flag", 32'(flag_out), 0);

        // R6 output compare actions: toggle, set, clear
        exp = 1'b0;
        for (int k = 0; k < 3; k++) begin
            ch_edge = 2'(oc_el[k]);
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < 8; c++) begin
                    cnt_val = 16'(c);
                    cyc(1);
                    if (c == 5) begin
                        if (oc_el[k] == 1) exp = !exp;
                        else if (oc_el[k] == 3) exp = 1'b1;
                        else exp = 1'b0;
                    end
                    chk("R6 compare pin", 32'(pin_out), 32'(exp));
                end
            end
            chk("R6 pin_oe", 32'(pin_oe), 1);
        end

        // R9 flag: set beats clear, sticky, then cleared
        ch_edge = 2'b11; cnt_val = 16'd4; cyc(2);
        clr_flag();
        chk("R9 flag cleared", 32'(flag_out), 0);
        cnt_val = 16'd5; flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        chk("R9 event beats clear", 32'(flag_out), 1);
        cyc(3);
        chk("R9 flag sticky", 32'(flag_out), 1);
        clr_flag();
        chk("R9 clear strobe", 32'(flag_out), 0);

        // R7 edge-aligned PWM, period 8, all duty values
        ctr_mode = 0; ch_mode = 2'b10;
        for (int k = 0; k < 3; k++) begin
            ch_edge = 2'(pw_el[k]);
            for (int d = 0; d < 10; d++) begin
                wr16(16'(d));
                for (int p = 0; p < 3; p++) begin
                    for (int c = 0; c < 8; c++) begin
                        cnt_val = 16'(c);
                        cnt_wrap = (c == 0);
                        cyc(1);
                        if (p > 0)
                            chk("R7 edge PWM pin", 32'(pin_out),
                                32'((pw_el[k] == 2) ? (c < d) : !(c < d)));
                    end
                end
                cnt_wrap = 0;
            end
        end

        // R8 center-aligned PWM, triangle 0..6..1
        ctr_mode = 1; ch_mode = 2'b00;
        for (int k = 0; k < 2; k++) begin
            ch_edge = 2'(pw_el[k]);
            for (int d = 1; d < 6; d++) begin
                wr16(16'(d));
                for (int p = 0; p < 3; p++) begin
                    for (int i = 0; i < 12; i++) begin
                        int  c;
                        bit  hi;
                        c = (i <= 6) ? i : 12 - i;
                        cnt_val = 16'(c);
                        cnt_down = (i > 6);
                        cyc(1);
                        hi = (i > 6) ? (c <= d) : (c < d);
                        if (p > 0)
                            chk("R8 center PWM pin", 32'(pin_out),
                                32'((pw_el[k] == 2) ? hi : !hi));
                    end
                end
            end
        end
        cnt_down = 0;
        ch_edge = 2'b00; cyc(1);
        chk("R2 center idle pin_oe", 32'(pin_oe), 0);
        chk("R2 center idle pin_out", 32'(pin_out), 0);

        summary();
    end

endmodule